// File: doc/BRIEF.md
# Seconds Watchdog with Timed Reset Pulse

This block is a watchdog that counts whole seconds. Software controls it through one 8-bit control register, which also reports status. Writing the register with the run bit set loads a seconds count, and the block counts it down once per second. Software services the timer by writing the register again before the count runs out. If the count runs out while the timer is running, the block pulls a reset line low for a fixed number of milliseconds and then lets it go. It also sets a sticky expiry flag and stops itself, so the reset is not repeated.

A prescaler derives the millisecond and second ticks from the clock frequency parameter. Any register write restarts the second phase, so an interval always begins at the write. The reset line is active low and open drain. The block does not drive the pad itself. It outputs a pull-low enable that is registered, and the pad cell turns that enable into an open-drain driver.

Top module: `wdtp_watchdog`

## Requirements
- R1: The control register has three fields. Bit 7 is the run bit (1 = counting, 0 = stopped), bit 6 is the expiry flag, and bits 5:0 are the seconds value. Reads return all three fields as they stand.
- R2: While synchronous reset is held and after it is released, the register reads 0x00 and the pull-low output is 0.
- R3: Writes to bit 6 are ignored. A write can never set the expiry flag.
- R4: A write with the run bit set and seconds value N causes a timeout after N+1 second ticks. Second ticks fall every CLK_HZ cycles, with the first one 1000 millisecond ticks after the write. So the pull-low output rises between (N+1)*CLK_HZ - CLK_HZ/1000 - 1 and (N+1)*CLK_HZ + 1 cycles after the write.
- R5: A seconds value of 0 with the run bit set times out on the first second tick after the write.
- R6: On a timeout the pull-low output goes to 1 for exactly PULSE_MS milliseconds (PULSE_MS*CLK_HZ/1000 cycles) and then returns to 0.
- R7: On a timeout the expiry flag sets and the run bit clears in the same cycle. The seconds field is kept.
- R8: The expiry flag stays set through writes that have bit 7 = 1. It clears only on a write with bit 7 = 0.
- R9: Writing bit 7 = 0 before a timeout stops the count, and no pulse follows.
- R10: Writing the register while it is running reloads the count and restarts the interval. Writes repeated at intervals shorter than N+1 seconds never produce a pulse.
- R11: Bits 5:0 read back the programmed seconds value, not the remaining count, all the way through a countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value (registered) |
| rst_pull_low | output | 1 | 1 = pull the open-drain reset line low |

## Verification
The hardest case to reach is a servicing write that lands late in an interval. The reload has to win over a second tick in the same window, and the restarted prescaler phase must not let a stale tick slip through. The stimulus programs a one-second count and rewrites it every 1.5 seconds, which is deliberately past the one-second mark. This confirms that only the write-relative second phase decides the outcome. It then stops servicing and times the resulting pulse. A cycle-level behavioural model tracks the prescaler phase, so every write and tick alignment along the way is compared.

// File: rtl/wdtp_pkg.sv
package wdtp_pkg;

  localparam int REG_W  = 8;
  localparam int SEC_W  = 6;
  localparam int RUN_B  = 7;
  localparam int FLAG_B = 6;

  typedef struct packed {
    logic             run;
    logic             expired;
    logic [SEC_W-1:0] secs;
  } wdt_reg_t;

  // bits needed to hold values 0 .. n-1 (at least one)
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wdtp_tick_gen.sv
module wdtp_tick_gen
  import wdtp_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int MS_PER_S = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_restart,
  output logic ms_tick,
  output logic sec_tick
);

  localparam int MS_DIV = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int MW     = cnt_width(MS_DIV);
  localparam int SW     = cnt_width(MS_PER_S);
  localparam logic [MW-1:0] MS_LAST  = MW'(MS_DIV - 1);
  localparam logic [SW-1:0] SEC_LAST = SW'(MS_PER_S - 1);

  logic [MW-1:0] ms_cnt;
  logic [SW-1:0] sec_cnt;

  assign ms_tick  = (ms_cnt == MS_LAST);
  assign sec_tick = ms_tick && (sec_cnt == SEC_LAST);

  // free-running millisecond prescaler
  always_ff @(posedge clk) begin
    if (rst || ms_tick) ms_cnt <= '0;
    else                ms_cnt <= ms_cnt + 1'b1;
  end

  // second phase: counts millisecond ticks, restarted by register writes
  always_ff @(posedge clk) begin
    if (rst || sec_restart) sec_cnt <= '0;
    else if (ms_tick) begin
      if (sec_cnt == SEC_LAST) sec_cnt <= '0;
      else                     sec_cnt <= sec_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wdtp_ctrl.sv
module wdtp_ctrl
  import wdtp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             sec_tick,
  output wdt_reg_t         reg_q,
  output logic             fire
);

  wdt_reg_t         wr_view;
  logic [SEC_W-1:0] remain;

  assign wr_view = wdt_reg_t'(wr_data);
  // a write in the same cycle takes priority over expiry
  assign fire = !wr_en && reg_q.run && sec_tick && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q  <= '0;
      remain <= '0;
    end else if (wr_en) begin
      reg_q.run  <= wr_view.run;
      reg_q.secs <= wr_view.secs;
      remain     <= wr_view.secs;
      if (!wr_view.run) reg_q.expired <= 1'b0;
    end else if (reg_q.run && sec_tick) begin
      if (fire) begin
        reg_q.run     <= 1'b0;
        reg_q.expired <= 1'b1;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdtp_stretch.sv
module wdtp_stretch
  import wdtp_pkg::*;
#(
  parameter int PULSE_MS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic ms_tick,
  output logic pull_low
);

  localparam int PW = cnt_width(PULSE_MS + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_MS);

  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_low <= 1'b0;
      left     <= '0;
    end else if (fire) begin
      pull_low <= 1'b1;
      left     <= LOAD;
    end else if (pull_low && ms_tick) begin
      if (left == PW'(1)) begin
        pull_low <= 1'b0;
        left     <= '0;
      end else begin
        left <= left - 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdtp_watchdog.sv
module wdtp_watchdog
  import wdtp_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int PULSE_MS = 4,
  parameter int MS_PER_S = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       rst_pull_low
);

  logic     ms_tick;
  logic     sec_tick;
  logic     fire;
  wdt_reg_t reg_q;

  wdtp_tick_gen #(.CLK_HZ(CLK_HZ), .MS_PER_S(MS_PER_S)) u_ticks (
    .clk(clk), .rst(rst), .sec_restart(wr_en),
    .ms_tick(ms_tick), .sec_tick(sec_tick)
  );

  wdtp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .sec_tick(sec_tick), .reg_q(reg_q), .fire(fire)
  );

  wdtp_stretch #(.PULSE_MS(PULSE_MS)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .ms_tick(ms_tick),
    .pull_low(rst_pull_low)
  );

  assign rd_data = reg_q;

endmodule

// File: rtl/wdtp_checker.sv
module wdtp_checker #(
  parameter int PULSE_CYC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       rst_pull_low
);

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !rst_pull_low) run_len <= 0;
    else                      run_len <= run_len + 1;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_pull_low) |-> run_len == PULSE_CYC); // R6

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_len <= PULSE_CYC); // R6

  AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pull_low) |-> (rd_data[6] && !rd_data[7])); // R7

  AST_FLAG_NOT_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[6] && !rd_data[6]) |=> !rd_data[6]); // R3

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[7]) |=> !rd_data[6]); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rd_data[6] && !(wr_en && !wr_data[7])) |=> rd_data[6]); // R8

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[7] && !wr_en) |=> !$rose(rst_pull_low)); // R9

  AST_FIELD_HELD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data[5:0])); // R11

endmodule

bind wdtp_watchdog wdtp_checker #(.PULSE_CYC(PULSE_MS * (CLK_HZ / 1000))) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .rst_pull_low(rst_pull_low)
);

// File: tb/wdtp_watchdog_tb.sv
module wdtp_watchdog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 2000;
  localparam int PULSE_MS   = 4;
  localparam int MS_DIV     = CLK_HZ / 1000;
  localparam int SEC_CYC    = CLK_HZ;
  localparam int PULSE_CYC  = PULSE_MS * MS_DIV;
  localparam int LIMIT      = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rst_pull_low;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  bit started = 0;

  wdtp_watchdog #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS), .MS_PER_S(1000)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rst_pull_low(rst_pull_low)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_ms = 0, m_sec = 0, m_en = 0, m_st = 0, m_field = 0, m_rem = 0, m_pulse = 0;

  always @(posedge clk) begin
    bit ms_t, sec_t, fire;
    started = 1;
    cycles++;
    if (rst) begin
      m_ms = 0; m_sec = 0; m_en = 0; m_st = 0; m_field = 0; m_rem = 0; m_pulse = 0;
    end else begin
      ms_t  = (m_ms == MS_DIV - 1);
      sec_t = ms_t && (m_sec == 999);
      m_ms  = ms_t ? 0 : m_ms + 1;
      fire  = 0;
      if (m_pulse > 0) m_pulse--;
      if (wr_en) begin
        m_en = wr_data[7];
        m_field = wr_data[5:0];
        m_rem = m_field;
        if (!wr_data[7]) m_st = 0;
        m_sec = 0;
      end else begin
        if (ms_t) m_sec = (m_sec == 999) ? 0 : m_sec + 1;
        if (m_en != 0 && sec_t) begin
          if (m_rem == 0) begin m_en = 0; m_st = 1; fire = 1; end
          else m_rem--;
        end
      end
      if (fire) m_pulse = PULSE_CYC;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      logic [7:0] exp_rd;
      exp_rd = {m_en[0], m_st[0], m_field[5:0]};
      chk(rd_data === exp_rd, "R1/R7/R8 model readback", rd_data, exp_rd);
      chk(rst_pull_low === (m_pulse > 0), "R4/R6/R9 model pulse", rst_pull_low, (m_pulse > 0));
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts cycles until the reset pull starts; -1 if not within max
  task automatic wait_rise(input int max, output int n);
    n = -1;
    for (int i = 0; i < max; i++) begin
      if (rst_pull_low) begin n = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic pulse_len(output int w);
    w = 0;
    while (rst_pull_low && w < 10 * PULSE_CYC) begin w++; @(negedge clk); end
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (rst_pull_low) seen++;
      @(negedge clk);
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  initial begin
    int n, w, lo, hi;
    idle(5);
    chk(rd_data == 8'h00, "R2 reset register", rd_data, 8'h00);
    chk(rst_pull_low == 1'b0, "R2 reset pull", rst_pull_low, 0);
    rst = 1'b0;
    idle(3);
    chk(rd_data == 8'h00, "R2 after reset register", rd_data, 8'h00);

    // flag bit written while stopped: ignored
    wr(8'h45);
    chk(rd_data == 8'h05, "R3 write to flag ignored", rd_data, 8'h05);
    chk(rd_data[5:0] == 6'd5, "R1 seconds field", rd_data[5:0], 5);
    quiet(3000, "R9 stopped timer stays quiet");

    // count of zero
    wr(8'h80);
    wait_rise(3 * SEC_CYC, n);
    lo = SEC_CYC - MS_DIV - 2; hi = SEC_CYC + 1;
    chk(n >= lo && n <= hi, "R5 zero count timeout time", n, SEC_CYC);
    idle(1);
    chk(rd_data == 8'h40, "R7 flags after timeout", rd_data, 8'h40);
    pulse_len(w);
    chk(w == PULSE_CYC - 1, "R6 pulse width", w + 1, PULSE_CYC);
    chk(rst_pull_low == 1'b0, "R6 released", rst_pull_low, 0);

    // flag sticky across run writes, cleared by stop write
    wr(8'hC3);
    chk(rd_data == 8'hC3, "R8 flag kept by run write", rd_data, 8'hC3);
    wr(8'h82);
    chk(rd_data[6] == 1'b1, "R8 flag still set", rd_data[6], 1);
    idle(SEC_CYC);
    chk(rd_data[5:0] == 6'd2, "R11 field holds programmed value", rd_data[5:0], 2);
    wr(8'h02);
    chk(rd_data == 8'h02, "R8 flag cleared by stop write", rd_data, 8'h02);
    quiet(4 * SEC_CYC, "R9 stop before expiry gives no pulse");

    // servicing: 1 s count, rewritten every 1.5 s
    wr(8'h81);
    for (int k = 0; k < 3; k++) begin
      quiet(SEC_CYC + SEC_CYC / 2, "R10 serviced timer quiet");
      wr(8'h81);
    end
    chk(rd_data == 8'h81, "R10 still running", rd_data, 8'h81);
    wait_rise(4 * SEC_CYC, n);
    lo = 2 * SEC_CYC - MS_DIV - 2; hi = 2 * SEC_CYC + 1;
    chk(n >= lo && n <= hi, "R4 timeout after N+1 seconds", n, 2 * SEC_CYC);
    idle(1);
    chk(rd_data == 8'h41, "R7 run cleared, field kept", rd_data, 8'h41);
    idle(PULSE_CYC + 4);
    chk(rst_pull_low == 1'b0, "R6 pulse ended", rst_pull_low, 0);

    // N = 2 timing
    wr(8'h82);
    wait_rise(5 * SEC_CYC, n);
    lo = 3 * SEC_CYC - MS_DIV - 2; hi = 3 * SEC_CYC + 1;
    chk(n >= lo && n <= hi, "R4 timeout with N=2", n, 3 * SEC_CYC);
    idle(PULSE_CYC + 4);
    wr(8'h00);
    chk(rd_data == 8'h00, "R8 cleared at end", rd_data, 8'h00);
    idle(5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", LIMIT, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule